// File: doc/BRIEF.md
# Write-Enable Latch Guard for a Serial Memory Slave

This block sits between a byte-oriented serial slave front end and the write engine of a nonvolatile memory. For each received data byte, the front end presents two things: whether the current target is the control register or the memory array, and the byte itself. The guard then decides whether the byte is acknowledged. A volatile write-enable latch controls whether array writes are allowed. That latch changes only when the control register receives one of two exact byte values.

When a stop strobe arrives after an acknowledged array byte, the guard raises a one-cycle commit request to the write engine. It then holds a busy flag for a fixed number of cycles, which stands for the self-timed write cycle. Bytes that arrive while busy is high are refused. Writes that only change the latch never start a write cycle, so the slave is ready again right after the stop.

Top module: `wel_write_guard`

## Requirements
- R1: Reset leaves the latch clear, busy low, commit_req low and ack_valid low.
- R2: A control-register byte equal to the set pattern (only bit EN_BIT high, 8'h02 with the defaults) is acknowledged and sets the latch.
- R3: A control-register byte of all zeros is acknowledged and clears the latch.
- R4: Any other control-register byte is not acknowledged and leaves the latch unchanged.
- R5: An array byte received while the latch is clear is not acknowledged, and the following stop gives no commit.
- R6: An array byte received while the latch is set and busy is low is acknowledged, and the following stop requests a commit.
- R7: A stop that follows only control-register bytes gives no commit, and busy stays low.
- R8: commit_req is a one-cycle pulse in the cycle after the stop strobe, and busy is high for exactly BUSY_CYC cycles starting in that same cycle.
- R9: A byte presented while busy is high is not acknowledged and has no effect, even the set or clear pattern. A byte presented in the first cycle after busy falls is handled normally.
- R10: ack_valid is high exactly in the cycle after each byte strobe, with ack_ok carrying the decision. ack_valid is low otherwise.
- R11: The latch stays set through array writes, commits and busy periods until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| byte_valid | input | 1 | Strobe: a data byte has been received |
| byte_data | input | DATA_W | Received data byte |
| tgt_ctrl | input | 1 | 1 = target is control register, 0 = memory array |
| stop_pulse | input | 1 | Strobe: stop condition seen (never together with byte_valid) |
| ack_valid | output | 1 | Acknowledge decision is valid this cycle |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| commit_req | output | 1 | One-cycle request to start a self-timed write |
| busy | output | 1 | Self-timed write in progress |

## Verification
The guard can receive a new data byte in the same cycle that its busy countdown expires, so refusal and acceptance meet at one clock edge. The bench waits on a commit until the last cycle in which busy is still seen high and presents an array byte there, which must be refused. It then repeats the sequence and presents the byte one cycle later, once busy reads low, and that byte must be acknowledged. Every control-register byte value is also swept from both latch states. After each write, the latch is probed through the acknowledge of an array byte.

// File: rtl/wel_guard_pkg.sv
package wel_guard_pkg;

  // Classification of a byte written to the control register
  typedef enum logic [1:0] {
    CLS_SET   = 2'd0,
    CLS_CLR   = 2'd1,
    CLS_OTHER = 2'd2
  } ctl_cls_e;

  // One-hot pattern that sets the latch
  function automatic logic [31:0] en_pattern(input int unsigned bitpos);
    return 32'(1) << bitpos;
  endfunction

  // Classify a byte against the set / clear patterns
  function automatic ctl_cls_e classify(input logic [31:0] b, input int unsigned bitpos);
    if (b == en_pattern(bitpos)) return CLS_SET;
    if (b == 32'd0)              return CLS_CLR;
    return CLS_OTHER;
  endfunction

endpackage

// File: rtl/wel_ctl_decode.sv
module wel_ctl_decode #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_BIT = 1
) (
  input  logic [DATA_W-1:0]       byte_data,
  output wel_guard_pkg::ctl_cls_e cls
);
  import wel_guard_pkg::*;

  localparam int unsigned PAD_W = 32 - DATA_W;

  generate
    if (PAD_W == 0) begin : g_full
      assign cls = classify(byte_data, EN_BIT);
    end else begin : g_pad
      assign cls = classify({{PAD_W{1'b0}}, byte_data}, EN_BIT);
    end
  endgenerate
endmodule

// File: rtl/wel_latch.sv
module wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= 1'b0;
    else if (set_req) q <= 1'b1;
    else if (clr_req) q <= 1'b0;
  end
endmodule

// File: rtl/wel_busy_timer.sv
module wel_busy_timer #(
  parameter int unsigned BUSY_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/wel_write_guard.sv
module wel_write_guard #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned EN_BIT   = 1,
  parameter int unsigned BUSY_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              tgt_ctrl,
  input  logic              stop_pulse,
  output logic              ack_valid,
  output logic              ack_ok,
  output logic              commit_req,
  output logic              busy
);
  import wel_guard_pkg::*;

  // Named internal events (visible to the bound checker)
  ctl_cls_e cls_w;
  logic     is_set_w, is_clr_w;
  logic     accept_w, ctrl_set_w, ctrl_clr_w, arr_take_w;
  logic     commit_fire_w;
  logic     latch_q;
  logic     pending_q;

  wel_ctl_decode #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_dec (
    .byte_data (byte_data),
    .cls       (cls_w)
  );

  assign is_set_w   = (cls_w == CLS_SET);
  assign is_clr_w   = (cls_w == CLS_CLR);
  assign accept_w   = byte_valid && !busy;
  assign ctrl_set_w = accept_w &&  tgt_ctrl && is_set_w;
  assign ctrl_clr_w = accept_w &&  tgt_ctrl && is_clr_w;
  assign arr_take_w = accept_w && !tgt_ctrl && latch_q;

  wel_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (ctrl_set_w),
    .clr_req (ctrl_clr_w),
    .q       (latch_q)
  );

  // An acknowledged array byte waits here for the stop strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending_q <= 1'b0;
    else if (stop_pulse) pending_q <= 1'b0;
    else if (arr_take_w) pending_q <= 1'b1;
  end

  assign commit_fire_w = stop_pulse && pending_q && !busy;

  wel_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_fire_w),
    .busy  (busy)
  );

  // Registered acknowledge decision and commit pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid  <= 1'b0;
      ack_ok     <= 1'b0;
      commit_req <= 1'b0;
    end else begin
      ack_valid  <= byte_valid;
      ack_ok     <= ctrl_set_w || ctrl_clr_w || arr_take_w;
      commit_req <= commit_fire_w;
    end
  end
endmodule

// File: rtl/wel_guard_chk.sv
module wel_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic tgt_ctrl,
  input logic stop_pulse,
  input logic ack_valid,
  input logic ack_ok,
  input logic commit_req,
  input logic busy,
  input logic latch_q,
  input logic is_set_w,
  input logic is_clr_w
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!latch_q && !busy && !commit_req && !ack_valid));

  // R2
  a_r2_set_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !busy && tgt_ctrl && is_set_w) |=> (latch_q && ack_ok));

  // R3
  a_r3_clear_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !busy && tgt_ctrl && is_clr_w) |=> (!latch_q && ack_ok));

  // R4
  a_r4_other_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && tgt_ctrl && !is_set_w && !is_clr_w) |=> (!ack_ok && $stable(latch_q)));

  // R5
  a_r5_array_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !tgt_ctrl && !latch_q) |=> !ack_ok);

  // R7
  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> $past(stop_pulse));

  // R8
  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> !commit_req);
  a_r8_busy_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |-> busy);
  a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> commit_req);

  // R9
  a_r9_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && busy) |=> (ack_valid && !ack_ok && $stable(latch_q)));

  // R10
  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> ack_valid);
  a_r10_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> !ack_valid);
endmodule

bind wel_write_guard wel_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .tgt_ctrl   (tgt_ctrl),
  .stop_pulse (stop_pulse),
  .ack_valid  (ack_valid),
  .ack_ok     (ack_ok),
  .commit_req (commit_req),
  .busy       (busy),
  .latch_q    (latch_q),
  .is_set_w   (is_set_w),
  .is_clr_w   (is_clr_w)
);

// File: tb/tb_wel_write_guard.sv
module tb_wel_write_guard;
  localparam int unsigned DW   = 8;
  localparam int unsigned EB   = 1;
  localparam int unsigned BUSY = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_valid = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          tgt_ctrl = 1'b0;
  logic          stop_pulse = 1'b0;
  logic          ack_valid, ack_ok, commit_req, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wel_write_guard #(.DATA_W(DW), .EN_BIT(EB), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .tgt_ctrl(tgt_ctrl), .stop_pulse(stop_pulse), .ack_valid(ack_valid),
    .ack_ok(ack_ok), .commit_req(commit_req), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one byte at a falling edge; judge the decision one cycle later (R10)
  task automatic send_byte(input bit ctrl, input logic [DW-1:0] d, input bit exp_ack, input string req);
    byte_valid = 1'b1; byte_data = d; tgt_ctrl = ctrl;
    @(negedge clk);
    byte_valid = 1'b0;
    check(ack_valid == 1'b1, "R10", int'(ack_valid), 1);
    check(ack_ok == exp_ack, req, int'(ack_ok), int'(exp_ack));
  endtask

  // Stop strobe; on commit, measure the busy window (R8)
  task automatic send_stop(input bit exp_commit, input string req);
    int len;
    stop_pulse = 1'b1;
    @(negedge clk);
    stop_pulse = 1'b0;
    check(commit_req == exp_commit, req, int'(commit_req), int'(exp_commit));
    check(busy == exp_commit, req, int'(busy), int'(exp_commit));
    if (exp_commit) begin
      len = 0;
      while (busy && len < 4 * BUSY) begin
        len++;
        @(negedge clk);
        check(commit_req == 1'b0, "R8", int'(commit_req), 0);
      end
      check(len == BUSY, "R8", len, BUSY);
    end
  endtask

  // Read the latch through the acknowledge of an array byte (R5/R6/R11)
  task automatic probe_latch(input bit exp_q, input string req);
    send_byte(1'b0, 8'hA5, exp_q, req);
    send_stop(exp_q, req);
  endtask

  function automatic bit model_ack(input int v);
    return (v == (1 << EB)) || (v == 0);
  endfunction

  function automatic bit model_next(input int v, input bit cur);
    if (v == (1 << EB)) return 1'b1;
    if (v == 0)         return 1'b0;
    return cur;
  endfunction

  initial begin
    #(20 * 60000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && commit_req == 0 && ack_valid == 0, "R1", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack_valid == 0, "R10", int'(ack_valid), 0);
    // R1 / R5: latch is clear after reset
    probe_latch(1'b0, "R5");

    // R2 R3 R4 R7: sweep every control byte from both latch states
    for (int v = 0; v < 256; v++) begin
      for (int s = 0; s < 2; s++) begin
        bit q;
        q = bit'(s);
        send_byte(1'b1, q ? DW'(1 << EB) : DW'(0), 1'b1, q ? "R2" : "R3");
        send_byte(1'b1, DW'(v), model_ack(v),
                  (v == (1 << EB)) ? "R2" : (v == 0) ? "R3" : "R4");
        send_stop(1'b0, "R7");
        q = model_next(v, q);
        probe_latch(q, q ? "R6" : "R4");
      end
    end

    // R11: latch persists across commits
    send_byte(1'b1, DW'(1 << EB), 1'b1, "R2");
    probe_latch(1'b1, "R11");
    probe_latch(1'b1, "R11");

    // R9: byte on last busy cycle is refused, incl. clear pattern
    send_byte(1'b0, 8'h11, 1'b1, "R6");
    stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
    check(commit_req == 1'b1, "R8", int'(commit_req), 1);
    repeat (BUSY - 1) @(negedge clk);
    check(busy == 1'b1, "R9", int'(busy), 1);
    send_byte(1'b1, 8'h00, 1'b0, "R9");
    check(busy == 1'b0, "R9", int'(busy), 0);
    probe_latch(1'b1, "R9");

    // R9: array byte on last busy cycle refused, no commit follows
    send_byte(1'b0, 8'h22, 1'b1, "R6");
    stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
    repeat (BUSY - 1) @(negedge clk);
    send_byte(1'b0, 8'h33, 1'b0, "R9");
    send_stop(1'b0, "R9");

    // R9: byte in first cycle after busy falls is accepted
    send_byte(1'b0, 8'h44, 1'b1, "R6");
    stop_pulse = 1'b1; @(negedge clk); stop_pulse = 1'b0;
    repeat (BUSY) @(negedge clk);
    check(busy == 1'b0, "R9", int'(busy), 0);
    send_byte(1'b0, 8'h55, 1'b1, "R9");
    send_stop(1'b1, "R9");

    // R3 then R5: clear and confirm array locked
    send_byte(1'b1, 8'h00, 1'b1, "R3");
    probe_latch(1'b0, "R5");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule